// File: doc/BRIEF.md
# Wrapping DMA Address Generator

This block generates the byte address for every data beat on one side of a DMA channel. A load presents a start pointer and a 32-bit sequence word. The sequence word selects the bus width, the burst length, a wrap window and byte reversal of the data path. The loaded pointer becomes both the current address and the window base. Each accepted beat then moves the address forward by the bus width in bytes. When a wrap window is selected and its size in bytes has been consumed, the address returns to the base.

The same module is instantiated twice per channel, and a parameter picks the side. The memory side has wrap windows from 32 to 2048 words and a burst counter that marks the final beat of each burst. The device side has windows from 1 to 64 words, which lets it hold on a single FIFO register or cycle over a small register bank; every one of its beats is marked final. A word is 4 bytes. Bus handshaking belongs to the surrounding channel logic.

Top module: `wrap_addr_gen`

## Requirements
- R1: After reset, addr_o is 0, load_err_o and cfg_err_o are 0, and last_o is 1. beat_i has no effect on addr_o until a load has been accepted.
- R2: A load with ptr_i[1:0] equal to 0 is accepted, and addr_o equals ptr_i in the cycle after load_i. load_i has priority over beat_i.
- R3: A load with ptr_i[1:0] not equal to 0 is rejected. In the next cycle load_err_o is 1, and the address, base and configuration are unchanged. The next accepted load clears load_err_o.
- R4: The width field is seq_i[30:28]. Codes 0 to 4 select 1, 2, 4, 8 and 16 bytes, and each accepted beat adds that many bytes to the address.
- R5: The wrap field is seq_i[18:16]. On the memory side, code k from 1 to 7 selects a window of 32·2^(k-1) words. When the byte offset from the base would reach the window size, the address returns to the base.
- R6: On the device side, wrap code k from 1 to 7 selects a window of 2^(k-1) words. A window no larger than one beat keeps the address constant at the base.
- R7: The burst field is seq_i[26:24], and only the memory side uses it. Codes 4, 5 and 6 select 1, 4 and 8 beats. last_o is 1 on the final beat of each burst, counting accepted beats from the load. On the device side last_o is always 1.
- R8: A width code of 5 to 7, or a memory-side burst code other than 4 to 6, sets cfg_err_o in the cycle after the load. While cfg_err_o is set, beats do not move the address. A valid load clears cfg_err_o.
- R9: When seq_i[27] was 1 at the last accepted load, data_o is data_i with its byte order reversed. Otherwise data_o equals data_i. This path is combinational.
- R10: Wrap code 0 means no wrap, and the address advances linearly from the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load pointer and sequence word |
| ptr_i | input | ADDR_W | Start pointer |
| seq_i | input | 32 | Sequence configuration word |
| beat_i | input | 1 | A beat was accepted this cycle |
| data_i | input | DATA_W | Beat data in |
| addr_o | output | ADDR_W | Current beat address |
| last_o | output | 1 | Current beat ends a burst |
| data_o | output | DATA_W | Beat data, byte-swapped if enabled |
| load_err_o | output | 1 | Last load rejected for misalignment |
| cfg_err_o | output | 1 | Loaded sequence word has invalid width or burst |

## Verification
The hardest condition to reach from the ports is the return to base on the largest memory window. It needs thousands of accepted beats on a single load, and any idle cycle on the way must leave the address alone. The bench sweeps every width and wrap code on both sides from shared stimulus. For each combination it runs one full window plus a few extra beats, with regular idle gaps. The other cases are driven directly: a misaligned load after beats have already been taken, a burst code that is bad on the memory side but ignored on the device side, and a beat window narrower than one beat.

// File: rtl/wag_pkg.sv
package wag_pkg;

    localparam int SEQ_W     = 32;
    localparam int WIDTH_LSB = 28;
    localparam int SWAP_BIT  = 27;
    localparam int BURST_LSB = 24;
    localparam int WRAP_LSB  = 16;
    localparam int BLEN_W    = 4;

    typedef struct packed {
        logic [2:0] width;
        logic       swap;
        logic [2:0] burst;
        logic [2:0] wrap;
    } seq_cfg_t;

    function automatic seq_cfg_t unpack_seq(input logic [SEQ_W-1:0] s);
        seq_cfg_t c;
        c.width = s[WIDTH_LSB +: 3];
        c.swap  = s[SWAP_BIT];
        c.burst = s[BURST_LSB +: 3];
        c.wrap  = s[WRAP_LSB +: 3];
        return c;
    endfunction

endpackage

// File: rtl/wag_cfg_decode.sv
module wag_cfg_decode
    import wag_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_SHIFT = 5,
    parameter int WIN_W     = 14,
    parameter bit DEV_SIDE  = 1'b0
) (
    input  seq_cfg_t            cfg_i,
    output logic [ADDR_W-1:0]   step_o,
    output logic [WIN_W-1:0]    win_o,
    output logic                wrap_en_o,
    output logic [BLEN_W-1:0]   blen_o,
    output logic                bad_o
);

    logic width_bad;
    logic burst_bad;

    always_comb begin
        step_o    = ADDR_W'(1) << cfg_i.width;
        width_bad = (cfg_i.width > 3'd4);
        wrap_en_o = (cfg_i.wrap != 3'd0);
        if (wrap_en_o) begin
            win_o = WIN_W'(4) << (WIN_SHIFT + int'(cfg_i.wrap) - 1);
        end else begin
            win_o = '0;
        end
    end

    generate
        if (DEV_SIDE) begin : g_dev_burst
            assign blen_o    = BLEN_W'(1);
            assign burst_bad = 1'b0;
        end else begin : g_mem_burst
            always_comb begin
                burst_bad = 1'b0;
                case (cfg_i.burst)
                    3'd4:    blen_o = BLEN_W'(1);
                    3'd5:    blen_o = BLEN_W'(4);
                    3'd6:    blen_o = BLEN_W'(8);
                    default: begin
                        blen_o    = BLEN_W'(1);
                        burst_bad = 1'b1;
                    end
                endcase
            end
        end
    endgenerate

    assign bad_o = width_bad | burst_bad;

endmodule

// File: rtl/wag_burst_ctr.sv
module wag_burst_ctr
    import wag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              adv_i,
    input  logic [BLEN_W-1:0] len_i,
    output logic              last_o
);

    logic [BLEN_W-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == (len_i - BLEN_W'(1)));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = last_o ? '0 : cnt_q + BLEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7
    restart_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear_i && last_o) |=> (cnt_q == '0));

endmodule

// File: rtl/wag_swap.sv
module wag_swap #(
    parameter int DATA_W = 32
) (
    input  logic              en_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] rev;

    generate
        for (genvar i = 0; i < NB; i++) begin : g_byte
            assign rev[8*i +: 8] = data_i[8*(NB-1-i) +: 8];
        end
    endgenerate

    assign data_o = en_i ? rev : data_i;

endmodule

// File: rtl/wrap_addr_gen.sv
module wrap_addr_gen
    import wag_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 32,
    parameter bit DEV_SIDE      = 1'b0,
    parameter int MEM_WIN_SHIFT = 5,
    parameter int DEV_WIN_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [SEQ_W-1:0]  seq_i,
    input  logic              beat_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o,
    output logic [DATA_W-1:0] data_o,
    output logic              load_err_o,
    output logic              cfg_err_o
);

    localparam int WIN_SHIFT = DEV_SIDE ? DEV_WIN_SHIFT : MEM_WIN_SHIFT;
    localparam int WIN_W     = WIN_SHIFT + 9;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] off;
        logic [ADDR_W-1:0] step;
        logic [WIN_W-1:0]  win;
        logic [BLEN_W-1:0] blen;
        logic              wrap_en;
        logic              swap;
        logic              cfg_err;
        logic              load_err;
        logic              loaded;
    } gen_state_t;

    gen_state_t st_d, st_q;

    seq_cfg_t          cfg;
    logic [ADDR_W-1:0] dec_step;
    logic [WIN_W-1:0]  dec_win;
    logic              dec_wrap_en;
    logic [BLEN_W-1:0] dec_blen;
    logic              dec_bad;
    logic [ADDR_W-1:0] off_nx;
    logic              adv;
    logic              clr;

    assign cfg = unpack_seq(seq_i);

    wag_cfg_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_SHIFT(WIN_SHIFT),
        .WIN_W    (WIN_W),
        .DEV_SIDE (DEV_SIDE)
    ) u_decode (
        .cfg_i    (cfg),
        .step_o   (dec_step),
        .win_o    (dec_win),
        .wrap_en_o(dec_wrap_en),
        .blen_o   (dec_blen),
        .bad_o    (dec_bad)
    );

    always_comb begin
        st_d   = st_q;
        adv    = 1'b0;
        clr    = 1'b0;
        off_nx = st_q.off + st_q.step;
        if (load_i) begin
            if (ptr_i[1:0] != 2'b00) begin
                st_d.load_err = 1'b1;
            end else begin
                st_d.addr     = ptr_i;
                st_d.base     = ptr_i;
                st_d.off      = '0;
                st_d.step     = dec_step;
                st_d.win      = dec_win;
                st_d.wrap_en  = dec_wrap_en;
                st_d.blen     = dec_blen;
                st_d.swap     = cfg.swap;
                st_d.cfg_err  = dec_bad;
                st_d.load_err = 1'b0;
                st_d.loaded   = 1'b1;
                clr           = 1'b1;
            end
        end else if (beat_i && st_q.loaded && !st_q.cfg_err) begin
            adv = 1'b1;
            if (st_q.wrap_en && (off_nx >= ADDR_W'(st_q.win))) begin
                st_d.off  = '0;
                st_d.addr = st_q.base;
            end else begin
                st_d.off  = off_nx;
                st_d.addr = st_q.base + off_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.blen <= BLEN_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    wag_burst_ctr u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(clr),
        .adv_i  (adv),
        .len_i  (st_q.blen),
        .last_o (last_o)
    );

    wag_swap #(.DATA_W(DATA_W)) u_swap (
        .en_i  (st_q.swap),
        .data_i(data_i),
        .data_o(data_o)
    );

    assign addr_o     = st_q.addr;
    assign load_err_o = st_q.load_err;
    assign cfg_err_o  = st_q.cfg_err;

    // R2
    load_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ptr_i[1:0] == 2'b00) |=> (addr_o == $past(ptr_i)));

    // R3
    bad_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ptr_i[1:0] != 2'b00) |=> (load_err_o && $stable(addr_o)));

    // R8
    frozen_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cfg_err_o) |=> $stable(addr_o));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !beat_i) |=> $stable(addr_o));

    generate
        if (DEV_SIDE) begin : g_dev_chk
            // R7
            dev_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
                last_o);
        end
    endgenerate

endmodule

// File: tb/wrap_addr_gen_bench.sv
module wrap_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] ptr_i = '0;
    logic [31:0] seq_i = '0;
    logic        beat_i = 1'b0;
    logic [31:0] data_i = '0;

    logic [31:0] m_addr, d_addr, m_data, d_data;
    logic        m_last, d_last, m_lerr, d_lerr, m_cerr, d_cerr;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wrap_addr_gen #(.DEV_SIDE(1'b0)) u_wrap_addr_gen (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .ptr_i(ptr_i), .seq_i(seq_i),
        .beat_i(beat_i), .data_i(data_i), .addr_o(m_addr), .last_o(m_last),
        .data_o(m_data), .load_err_o(m_lerr), .cfg_err_o(m_cerr));

    wrap_addr_gen #(.DEV_SIDE(1'b1)) u_wrap_addr_gen_dev (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .ptr_i(ptr_i), .seq_i(seq_i),
        .beat_i(beat_i), .data_i(data_i), .addr_o(d_addr), .last_o(d_last),
        .data_o(d_data), .load_err_o(d_lerr), .cfg_err_o(d_cerr));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_seq(input int w, input int sw, input int b, input int wr);
        return (32'(w) << 28) | (32'(sw) << 27) | (32'(b) << 24) | (32'(wr) << 16);
    endfunction

    function automatic int win_bytes(input bit dev, input int wr);
        if (wr == 0) return 0;
        return dev ? (4 << (wr - 1)) : (4 << (wr + 4));
    endfunction

    function automatic logic [31:0] exp_addr(input bit dev, input logic [31:0] p,
                                             input int w, input int wr, input int n);
        int step;
        int wb;
        step = 1 << w;
        wb   = win_bytes(dev, wr);
        if (wb == 0) return p + 32'(n * step);
        if (step >= wb) return p;
        return p + 32'((n * step) % wb);
    endfunction

    function automatic bit exp_last(input bit dev, input int b, input int n);
        int len;
        if (dev) return 1'b1;
        len = (b == 4) ? 1 : (b == 5) ? 4 : 8;
        return (n % len) == (len - 1);
    endfunction

    task automatic do_load(input logic [31:0] p, input logic [31:0] s);
        @(negedge clk);
        load_i = 1'b1;
        ptr_i  = p;
        seq_i  = s;
        beat_i = 1'b0;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic beats(input int k);
        for (int i = 0; i < k; i++) begin
            beat_i = 1'b1;
            @(negedge clk);
        end
        beat_i = 1'b0;
    endtask

    // R2 R4 R5 R6 R7 R10: one load, then beats with idle gaps
    task automatic run(input logic [31:0] p, input int w, input int b, input int wr, input int nb);
        int n;
        logic [31:0] em, ed;
        string tag;
        do_load(p, mk_seq(w, 0, b, wr));
        chk(m_addr == p, "R2 mem load addr", m_addr, p);
        n = 0;
        tag = (wr == 0) ? "R10/R4" : "R5/R4";
        for (int i = 0; n < nb; i++) begin
            em = exp_addr(1'b0, p, w, wr, n);
            ed = exp_addr(1'b1, p, w, wr, n);
            chk(m_addr == em, {tag, " mem addr"}, m_addr, em);
            chk(d_addr == ed, "R6 dev addr", d_addr, ed);
            chk(m_last == exp_last(1'b0, b, n), "R7 mem last", 32'(m_last), 32'(exp_last(1'b0, b, n)));
            chk(d_last == 1'b1, "R7 dev last", 32'(d_last), 32'd1);
            beat_i = ((i % 5) != 2);
            @(negedge clk);
            if (beat_i) n++;
        end
        beat_i = 1'b0;
        em = exp_addr(1'b0, p, w, wr, n);
        chk(m_addr == em, {tag, " mem final addr"}, m_addr, em);
    endtask

    initial begin
        int nb;
        int wm;
        int wd;
        logic [31:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(m_addr == 0 && d_addr == 0, "R1 reset addr", m_addr | d_addr, 32'd0);
        chk(!m_lerr && !m_cerr && !d_lerr && !d_cerr, "R1 reset errors",
            32'({m_lerr, m_cerr, d_lerr, d_cerr}), 32'd0);
        chk(m_last && d_last, "R1 reset last", 32'({m_last, d_last}), 32'd3);
        beats(3);
        chk(m_addr == 0 && d_addr == 0, "R1 beat before load ignored", m_addr | d_addr, 32'd0);

        // R9: byte reversal
        do_load(32'h0000_1000, mk_seq(2, 1, 4, 0));
        data_i = 32'h1122_3344;
        #1;
        chk(m_data == 32'h4433_2211, "R9 mem swap", m_data, 32'h4433_2211);
        chk(d_data == 32'h4433_2211, "R9 dev swap", d_data, 32'h4433_2211);
        do_load(32'h0000_1000, mk_seq(2, 0, 4, 0));
        #1;
        chk(m_data == 32'h1122_3344, "R9 mem no swap", m_data, 32'h1122_3344);
        chk(d_data == 32'h1122_3344, "R9 dev no swap", d_data, 32'h1122_3344);

        // R8: invalid width on both sides
        do_load(32'h0000_2000, mk_seq(5, 0, 4, 1));
        chk(m_cerr && d_cerr, "R8 bad width flag", 32'({m_cerr, d_cerr}), 32'd3);
        beats(3);
        chk(m_addr == 32'h2000, "R8 mem frozen", m_addr, 32'h2000);
        chk(d_addr == 32'h2000, "R8 dev frozen", d_addr, 32'h2000);
        // R8: bad burst code affects memory side only
        do_load(32'h0000_3000, mk_seq(2, 0, 7, 3));
        chk(m_cerr && !d_cerr, "R8 bad burst flag", 32'({m_cerr, d_cerr}), 32'd2);
        beats(3);
        chk(m_addr == 32'h3000, "R8 mem frozen burst", m_addr, 32'h3000);
        chk(d_addr == 32'h300C, "R8 dev advances", d_addr, 32'h300C);
        do_load(32'h0000_3000, mk_seq(2, 0, 4, 0));
        chk(!m_cerr && !d_cerr, "R8 cleared", 32'({m_cerr, d_cerr}), 32'd0);

        // R3: misaligned load after beats
        do_load(32'h0000_4000, mk_seq(2, 0, 5, 0));
        beats(2);
        chk(m_addr == 32'h4008, "R3 pre addr", m_addr, 32'h4008);
        do_load(32'h0000_5002, mk_seq(0, 0, 6, 0));
        chk(m_lerr && d_lerr, "R3 reject flag", 32'({m_lerr, d_lerr}), 32'd3);
        chk(m_addr == 32'h4008 && d_addr == 32'h4008, "R3 addr kept", m_addr, 32'h4008);
        beats(1);
        chk(m_addr == 32'h400C, "R3 config kept", m_addr, 32'h400C);
        chk(m_last == 1'b1, "R3 burst count kept R7", 32'(m_last), 32'd1);
        do_load(32'h0000_6000, mk_seq(2, 0, 4, 0));
        chk(!m_lerr && !d_lerr, "R3 cleared", 32'({m_lerr, d_lerr}), 32'd0);

        // R4 R5 R6 R10: every width and wrap code
        for (int w = 0; w < 5; w++) begin
            for (int wr = 0; wr < 8; wr++) begin
                wm = win_bytes(1'b0, wr) >> w;
                wd = win_bytes(1'b1, wr) >> w;
                nb = ((wm > wd) ? wm : wd) + 6;
                if (wr == 0) nb = 12;
                p = 32'h4000_0000 + 32'((w * 8 + wr) * 256);
                run(p, w, 6, wr, nb);
            end
        end
        // R7: remaining burst codes
        run(32'h5000_0000, 2, 4, 1, 20);
        run(32'h5000_1000, 2, 5, 1, 20);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 180000 && !done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule